// File: doc/BRIEF.md
# Fractional Audio Master-Clock Divider

The block makes an audio master clock from a fast system clock at the rational ratio (F+1)/(D+1). F and D are the fraction and divide fields. A phase accumulator, clocked by the system clock, produces two outputs: a one-cycle clock-enable pulse for each output period, and a level output that approximates a square wave. With a 96 MHz system clock, F=1 and D=16 give about 11.294 MHz, which is 256 times a 44.117647 kHz sample rate. The same target is reached from 16, 24, 48, 72 and 120 MHz inputs with the ratios 12/17, 8/17, 4/17, 8/51 and 8/85.

A source select can bypass the divider. In that mode the level output follows an external clock pin directly. The enable pulse then marks each rising edge of that pin after it has been synchronised into the system-clock domain.

Configuration (F, D and source) is sampled into shadow registers only while the block is disabled, so field changes made while it runs have no effect. Switching sources glitch-free while running is not supported.

Top module: `audio_mclk_gen`

## Requirements
- R1: In divider mode (src_sel_i=0) with F ≤ D and en_i high, any k·(D+1) consecutive cycles contain exactly k·(F+1) cycles with mclk_en_o high.
- R2: In divider mode with 2·(F+1) ≤ D+1, mclk_o has exactly k·(F+1) rising edges in any k·(D+1) consecutive enabled cycles.
- R3: At default widths, D can be up to 255. The ratios 12/17, 8/17, 4/17, 8/51 and 8/85 are produced exactly.
- R4: frac_i, div_i and src_sel_i are captured on every edge at which en_i is low. Their values while en_i is high have no effect.
- R5: In divider mode with F > D, cfg_err_o is high, mclk_o and mclk_en_o stay low and locked_o stays low.
- R6: One edge after en_i is sampled low, mclk_en_o, mclk_o (divider mode) and locked_o are low, and the accumulator restarts from zero. After re-enabling, the first pulse appears on the ceil((D+1)/(F+1))-th edge.
- R7: In bypass mode (src_sel_i=1), mclk_o equals ext_clk_i without delay. mclk_en_o is high for exactly one cycle per rising edge of ext_clk_i, from the second system edge after the rise, and only while en_i is high. cfg_err_o is low.
- R8: During reset all outputs are low.
- R9: locked_o goes high on the first edge at which en_i is sampled high with a valid configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; configuration loads while low |
| frac_i | input | FRAC_W | Fraction field F |
| div_i | input | DIV_W | Divide field D |
| src_sel_i | input | 1 | 0 divider, 1 external clock |
| ext_clk_i | input | 1 | External clock for bypass |
| mclk_en_o | output | 1 | One-cycle pulse per master-clock period |
| mclk_o | output | 1 | Master-clock level |
| locked_o | output | 1 | Running with a usable configuration |
| cfg_err_o | output | 1 | Fraction exceeds divide in divider mode |

## Verification
The accumulator outputs are registered, so they are valid one edge after en_i is sampled high. They are periodic with period D+1 from that point. The bench therefore drives inputs at falling edges, skips one cycle, and counts pulses and level rises over whole periods, which makes every count exact. locked_o and the disable clearing are due one edge after en_i changes. The bypass pulse is due two edges after the external rise, and the bypass level at once. The bench samples at the matching falling edge, or 1 ns after driving for the level. A near-exhaustive sweep covers every F ≤ D for D from 1 to 20, followed by the target ratios.

// File: rtl/mclk_pkg.sv
package mclk_pkg;
  typedef enum logic {SRC_DIV = 1'b0, SRC_EXT = 1'b1} mclk_src_e;

  localparam int unsigned CMP_W = 16;

  function automatic logic ratio_bad(input logic [CMP_W-1:0] f, input logic [CMP_W-1:0] d);
    return f > d;
  endfunction
endpackage

// File: rtl/mclk_cfg_shadow.sv
module mclk_cfg_shadow #(
  parameter int unsigned FRAC_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              src_i,
  output logic [FRAC_W-1:0] frac_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              bypass_o,
  output logic              err_o
);
  import mclk_pkg::*;

  logic [FRAC_W-1:0] frac_q;
  logic [DIV_W-1:0]  div_q;
  logic              byp_q, err_q;
  logic              bad_w;

  assign bad_w = (mclk_src_e'(src_i) == SRC_DIV) &&
                 ratio_bad(CMP_W'(frac_i), CMP_W'(div_i));

  // load only while stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frac_q <= '0;
      div_q  <= '0;
      byp_q  <= 1'b0;
      err_q  <= 1'b0;
    end else if (!en_i) begin
      frac_q <= frac_i;
      div_q  <= div_i;
      byp_q  <= src_i;
      err_q  <= bad_w;
    end
  end

  assign frac_o   = frac_q;
  assign div_o    = div_q;
  assign bypass_o = byp_q;
  assign err_o    = err_q;

  p_cfg_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> $stable(frac_q) && $stable(div_q) && $stable(byp_q) && $stable(err_q));
endmodule

// File: rtl/mclk_phase_accum.sv
module mclk_phase_accum #(
  parameter int unsigned FRAC_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              pulse_o,
  output logic              level_o
);
  localparam int unsigned ACC_W = DIV_W + 3;

  logic [ACC_W-1:0] acc_q, mod_w, inc_w, half_w, sum_w, nxt_w;
  logic             wrap_w, pulse_q, level_q;

  // phase counted in half-periods: modulus 2(D+1), step 2(F+1)
  assign half_w = ACC_W'(div_i) + ACC_W'(1);
  assign mod_w  = half_w << 1;
  assign inc_w  = (ACC_W'(frac_i) + ACC_W'(1)) << 1;
  assign sum_w  = acc_q + inc_w;
  assign wrap_w = sum_w >= mod_w;
  assign nxt_w  = wrap_w ? sum_w - mod_w : sum_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      pulse_q <= 1'b0;
      level_q <= 1'b0;
    end else if (!run_i) begin
      acc_q   <= '0;
      pulse_q <= 1'b0;
      level_q <= 1'b0;
    end else begin
      acc_q   <= nxt_w;
      pulse_q <= wrap_w;
      level_q <= nxt_w >= half_w;
    end
  end

  assign pulse_o = pulse_q;
  assign level_o = level_q;

  p_acc_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> acc_q < mod_w);
  p_idle_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (acc_q == '0) && !pulse_q && !level_q);
endmodule

// File: rtl/mclk_ext_sync.sv
module mclk_ext_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  output logic pulse_o
);
  localparam int unsigned SH_W = STAGES + 1;

  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SH_W-2:0], ext_i};
  end

  assign pulse_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  p_one_shot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/audio_mclk_gen.sv
module audio_mclk_gen #(
  parameter int unsigned FRAC_W      = 8,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              src_sel_i,
  input  logic              ext_clk_i,
  output logic              mclk_en_o,
  output logic              mclk_o,
  output logic              locked_o,
  output logic              cfg_err_o
);
  logic [FRAC_W-1:0] frac_w;
  logic [DIV_W-1:0]  div_w;
  logic              byp_w, err_w, run_w;
  logic              div_pulse_w, div_level_w, ext_pulse_w;
  logic              locked_q;

  mclk_cfg_shadow #(.FRAC_W(FRAC_W), .DIV_W(DIV_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .frac_i   (frac_i),
    .div_i    (div_i),
    .src_i    (src_sel_i),
    .frac_o   (frac_w),
    .div_o    (div_w),
    .bypass_o (byp_w),
    .err_o    (err_w)
  );

  assign run_w = en_i && !byp_w && !err_w;

  mclk_phase_accum #(.FRAC_W(FRAC_W), .DIV_W(DIV_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_w),
    .frac_i  (frac_w),
    .div_i   (div_w),
    .pulse_o (div_pulse_w),
    .level_o (div_level_w)
  );

  mclk_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ext_i   (ext_clk_i),
    .pulse_o (ext_pulse_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) locked_q <= 1'b0;
    else         locked_q <= en_i && (byp_w || !err_w);
  end

  assign mclk_o    = byp_w ? ext_clk_i : div_level_w;
  assign mclk_en_o = byp_w ? (ext_pulse_w & en_i) : div_pulse_w;
  assign locked_o  = locked_q;
  assign cfg_err_o = err_w;

  p_err_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !mclk_en_o && !mclk_o && !locked_o);
  p_lock_follows_en_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !locked_o);
  p_bypass_no_div_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byp_w |=> !div_pulse_w && !div_level_w);
endmodule

// File: tb/tb_audio_mclk_gen.sv
`timescale 1ns/1ps
module tb_audio_mclk_gen;
  localparam int unsigned FRAC_W = 8;
  localparam int unsigned DIV_W  = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic [FRAC_W-1:0] frac_i = '0;
  logic [DIV_W-1:0]  div_i = '0;
  logic src_sel_i = 1'b0;
  logic ext_clk_i = 1'b0;
  logic mclk_en_o, mclk_o, locked_o, cfg_err_o;

  int checks = 0;
  int fails = 0;
  int pc = 0;
  int rc = 0;
  bit prev_lvl = 1'b0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  audio_mclk_gen #(.FRAC_W(FRAC_W), .DIV_W(DIV_W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .frac_i(frac_i), .div_i(div_i),
    .src_sel_i(src_sel_i), .ext_clk_i(ext_clk_i), .mclk_en_o(mclk_en_o),
    .mclk_o(mclk_o), .locked_o(locked_o), .cfg_err_o(cfg_err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    if (mclk_en_o) pc++;
    if (mclk_o && !prev_lvl) rc++;
    prev_lvl = mclk_o;
  endtask

  task automatic clr_counts();
    pc = 0;
    rc = 0;
    prev_lvl = mclk_o;
  endtask

  task automatic setup(input int f, input int d, input bit s);
    @(negedge clk_i);
    en_i = 1'b0;
    frac_i = FRAC_W'(f);
    div_i = DIV_W'(d);
    src_sel_i = s;
    @(negedge clk_i);
    @(negedge clk_i);
  endtask

  // run k periods of D+1 after one warm-up cycle
  task automatic measure(input int f, input int d, input int k, input string req);
    setup(f, d, 1'b0);
    en_i = 1'b1;
    @(negedge clk_i);
    clr_counts();
    for (int i = 0; i < k * (d + 1); i++) step();
    chk(pc == k * (f + 1), req, pc, k * (f + 1));
    if (2 * (f + 1) <= d + 1) chk(rc == k * (f + 1), "R2 level rises", rc, k * (f + 1));
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    // R8 reset
    repeat (3) @(negedge clk_i);
    chk(!mclk_en_o && !mclk_o && !locked_o && !cfg_err_o, "R8 reset outputs",
        {mclk_en_o, mclk_o, locked_o, cfg_err_o}, 0);
    rst_ni = 1'b1;

    // R1/R2 sweep
    for (int d = 1; d <= 20; d++)
      for (int f = 0; f <= d; f++)
        measure(f, d, 2, "R1 pulse count");

    // R3 target ratios and wide divide
    measure(11, 16, 3, "R3 12/17");
    measure(7, 16, 3, "R3 8/17");
    measure(3, 16, 3, "R3 4/17");
    measure(7, 50, 2, "R3 8/51");
    measure(7, 84, 2, "R3 8/85");
    measure(1, 255, 2, "R3 2/256");

    // R9 lock one edge after enable
    setup(1, 16, 1'b0);
    en_i = 1'b1;
    @(negedge clk_i);
    chk(locked_o == 1'b1, "R9 locked after enable", locked_o, 1);

    // R4 changes while running ignored
    frac_i = 8'd3;
    div_i = 8'd40;
    src_sel_i = 1'b1;
    ext_clk_i = 1'b1;
    @(negedge clk_i);
    clr_counts();
    for (int i = 0; i < 34; i++) step();
    chk(pc == 4, "R4 ratio held while running", pc, 4);
    chk(rc == 4, "R4 level still divided", rc, 4);
    ext_clk_i = 1'b0;

    // R6 disable clears within one edge
    en_i = 1'b0;
    frac_i = 8'd3;
    div_i = 8'd16;
    src_sel_i = 1'b0;
    @(negedge clk_i);
    chk(!mclk_en_o && !mclk_o && !locked_o, "R6 cleared on disable",
        {mclk_en_o, mclk_o, locked_o}, 0);
    @(negedge clk_i);
    en_i = 1'b1;
    n = 0;
    while (!mclk_en_o && n < 100) begin
      @(negedge clk_i);
      n++;
    end
    chk(n == (16 + 1 + 3) / (3 + 1), "R6 first pulse edge", n, (16 + 1 + 3) / (3 + 1));

    // R5 fraction above divide
    setup(5, 3, 1'b0);
    chk(cfg_err_o == 1'b1, "R5 error flag", cfg_err_o, 1);
    en_i = 1'b1;
    clr_counts();
    n = 0;
    for (int i = 0; i < 20; i++) begin
      step();
      if (mclk_o || locked_o) n++;
    end
    chk(pc == 0 && rc == 0 && n == 0, "R5 outputs quiet", pc + rc + n, 0);

    // R7 bypass
    setup(0, 0, 1'b1);
    chk(cfg_err_o == 1'b0, "R7 no error in bypass", cfg_err_o, 0);
    en_i = 1'b1;
    @(negedge clk_i);
    chk(locked_o == 1'b1, "R9 locked in bypass", locked_o, 1);
    ext_clk_i = 1'b1;
    #1;
    chk(mclk_o == 1'b1, "R7 level follows ext high", mclk_o, 1);
    @(negedge clk_i);
    chk(mclk_en_o == 1'b0, "R7 no pulse after one edge", mclk_en_o, 0);
    @(negedge clk_i);
    chk(mclk_en_o == 1'b1, "R7 pulse after two edges", mclk_en_o, 1);
    @(negedge clk_i);
    chk(mclk_en_o == 1'b0, "R7 pulse one cycle", mclk_en_o, 0);
    ext_clk_i = 1'b0;
    #1;
    chk(mclk_o == 1'b0, "R7 level follows ext low", mclk_o, 0);
    repeat (4) @(negedge clk_i);
    clr_counts();
    for (int p = 0; p < 10; p++) begin
      ext_clk_i = 1'b1;
      repeat (4) step();
      ext_clk_i = 1'b0;
      repeat (4) step();
    end
    repeat (4) step();
    chk(pc == 10, "R7 one pulse per ext edge", pc, 10);
    en_i = 1'b0;
    clr_counts();
    for (int p = 0; p < 3; p++) begin
      ext_clk_i = 1'b1;
      repeat (4) step();
      ext_clk_i = 1'b0;
      repeat (4) step();
    end
    chk(pc == 0, "R7 no pulse while disabled", pc, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule